// File: doc/BRIEF.md
# Parallel-Prefix Tree Adder

This block is a purely combinational N-bit binary adder with a carry input. Every operand bit first yields a generate flag (both bits set) and a propagate flag (bits differ). A logarithmic network of prefix cells then merges these flags into the group generate of every span that ends at bit 0. That value is the carry into the next bit. A final XOR stage forms the sum. The carry input is folded into the generate flag of bit 0, so the network never needs an extra column for it.

One parameter picks the prefix network. The choices are a dense tree with fanout two, a divide-and-conquer tree with fanout that grows at each level, a sparse up-sweep/down-sweep tree, and a hybrid that runs the dense tree on odd columns and then adds one fill-in level for the even columns. Only the selected network is elaborated. Each choice trades cell count, level count and fanout differently, and all of them produce the same arithmetic result. N must be a power of two, at least 2.

Top module: `pa_prefix_adder`

## Requirements
- R1: For every topology, `{cout_o, sum_o}` equals the (N+1)-bit value `a_i + b_i + cin_i`.
- R2: Parameter `TOPO` selects the network with the encoding 0 = dense fanout-2 tree (log2 N levels), 1 = divide-and-conquer tree (log2 N levels), 2 = sparse up/down tree (2·log2 N − 1 levels), 3 = odd-column hybrid (log2 N + 1 levels). All four produce identical outputs for identical inputs.
- R3: With both operands zero, `sum_o` equals `cin_i` in bit 0 and zero in every other bit, and `cout_o` is 0.
- R4: When every bit position propagates (`a_i ^ b_i` all ones), `cin_i` travels through the whole word: `cout_o` equals `cin_i` and every sum bit equals the inverse of `cin_i`.
- R5: The carry out of each bit position that the network produces equals the ripple recurrence `g[i] | (p[i] & carry[i-1])`. The network's final group propagate is zero in every column, which shows that each column's span reaches down to bit 0.
- R6: All-ones plus all-ones plus a carry-in of 1 gives all-ones in `sum_o` and 1 in `cout_o`.
- R7: A bit position where both operands are 0 stops the carry: the carry out of that bit is 0 whatever the lower bits hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | N | First operand |
| b_i | input | N | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | N | Sum bits |
| cout_o | output | 1 | Carry out of bit N−1 |

## Verification
Each time the inputs change, the assertions compare the full result with a reference addition. They also check the network's carry vector bit by bit against the ripple recurrence, check the stop behaviour of bits where both operands are 0, and confirm that every final column spans down to bit 0. None of these checks can tell whether the four networks agree with each other, or whether both word widths behave the same. The bench shows that by driving the same vectors into all eight instances at once. It uses a table of edge patterns, directed kill cases and a long pseudo-random run.

// File: rtl/pa_pkg.sv
package pa_pkg;

  typedef enum logic [1:0] {
    TOPO_KS = 2'd0,  // dense, fanout 2
    TOPO_SK = 2'd1,  // divide and conquer
    TOPO_BK = 2'd2,  // sparse up/down sweep
    TOPO_HC = 2'd3   // dense on odd columns + fill-in level
  } pa_topo_e;

  function automatic int pa_levels(pa_topo_e topo, int lg);
    case (topo)
      TOPO_BK: return 2 * lg - 1;
      TOPO_HC: return lg + 1;
      default: return lg;
    endcase
  endfunction

  // Column merged into column col at level lvl, or -1 for pass-through.
  function automatic int pa_partner(pa_topo_e topo, int lg, int lvl, int col);
    int d;
    case (topo)
      TOPO_KS: begin
        d = 1 << lvl;
        if (col >= d) return col - d;
      end
      TOPO_SK: begin
        if (((col >> lvl) & 1) == 1) return ((col >> lvl) << lvl) - 1;
      end
      TOPO_BK: begin
        if (lvl < lg) begin
          d = 1 << lvl;
          if (((col + 1) % (2 * d)) == 0) return col - d;
        end else begin
          d = 1 << (2 * lg - 2 - lvl);
          if ((((col + 1) % (2 * d)) == d) && (col >= 2 * d)) return col - d;
        end
      end
      default: begin
        if (lvl == 0) begin
          if ((col % 2) == 1) return col - 1;
        end else if (lvl == lg) begin
          if (((col % 2) == 0) && (col >= 2)) return col - 1;
        end else begin
          d = 1 << lvl;
          if (((col % 2) == 1) && (col >= d)) return col - d;
        end
      end
    endcase
    return -1;
  endfunction

endpackage

// File: rtl/pa_pg_stage.sv
module pa_pg_stage #(
  parameter int N = 32
) (
  input  logic [N-1:0] a_i,
  input  logic [N-1:0] b_i,
  input  logic         cin_i,
  output logic [N-1:0] g_o,
  output logic [N-1:0] p_o
);
  logic [N-1:0] gen_w;

  assign gen_w = a_i & b_i;
  assign p_o   = a_i ^ b_i;
  // fold carry-in into bit 0 so the network spans N columns only
  assign g_o   = {gen_w[N-1:1], gen_w[0] | (p_o[0] & cin_i)};
endmodule

// File: rtl/pa_pg_cell.sv
module pa_pg_cell (
  input  logic g_hi_i,
  input  logic p_hi_i,
  input  logic g_lo_i,
  input  logic p_lo_i,
  output logic g_o,
  output logic p_o
);
  assign g_o = g_hi_i | (p_hi_i & g_lo_i);
  assign p_o = p_hi_i & p_lo_i;
endmodule

// File: rtl/pa_prefix_net.sv
module pa_prefix_net
  import pa_pkg::*;
#(
  parameter int       N    = 32,
  parameter pa_topo_e TOPO = TOPO_KS
) (
  input  logic [N-1:0] g_i,
  input  logic [N-1:0] p_i,   // bit 0 expected zero (carry-in folded)
  output logic [N-1:0] grp_g_o
);
  localparam int LG = $clog2(N);
  localparam int NL = pa_levels(TOPO, LG);

  logic [NL:0][N-1:0] g_lv;
  logic [NL:0][N-1:0] p_lv;

  assign g_lv[0] = g_i;
  assign p_lv[0] = p_i;

  for (genvar lvl = 0; lvl < NL; lvl++) begin : gen_lvl
    for (genvar col = 0; col < N; col++) begin : gen_col
      localparam int J = pa_partner(TOPO, LG, lvl, col);
      if (J >= 0) begin : gen_cell
        pa_pg_cell u_cell (
          .g_hi_i (g_lv[lvl][col]),
          .p_hi_i (p_lv[lvl][col]),
          .g_lo_i (g_lv[lvl][J]),
          .p_lo_i (p_lv[lvl][J]),
          .g_o    (g_lv[lvl+1][col]),
          .p_o    (p_lv[lvl+1][col])
        );
      end else begin : gen_pass
        assign g_lv[lvl+1][col] = g_lv[lvl][col];
        assign p_lv[lvl+1][col] = p_lv[lvl][col];
      end
    end
  end

  assign grp_g_o = g_lv[NL];

  always_comb begin
    // R5: every final column must span to bit 0, whose propagate is forced low
    a_r5_full_span: assert (p_lv[NL] == '0)
      else $error("R5: final group propagate not zero: %h", p_lv[NL]);
    a_r5_ripple_bit0: assert (grp_g_o[0] == g_i[0])
      else $error("R5: column 0 carry mismatch");
    for (int i = 1; i < N; i++) begin
      a_r5_ripple: assert (grp_g_o[i] == (g_i[i] | (p_i[i] & grp_g_o[i-1])))
        else $error("R5: carry mismatch at column %0d", i);
      if (!g_i[i] && !p_i[i]) begin
        a_r7_kill: assert (!grp_g_o[i])
          else $error("R7: carry not killed at column %0d", i);
      end
    end
  end
endmodule

// File: rtl/pa_sum_stage.sv
module pa_sum_stage #(
  parameter int N = 32
) (
  input  logic [N-1:0] p_i,
  input  logic [N-1:0] grp_g_i,
  input  logic         cin_i,
  output logic [N-1:0] sum_o,
  output logic         cout_o
);
  assign sum_o  = p_i ^ {grp_g_i[N-2:0], cin_i};
  assign cout_o = grp_g_i[N-1];
endmodule

// File: rtl/pa_prefix_adder.sv
module pa_prefix_adder
  import pa_pkg::*;
#(
  parameter int       N    = 32,
  parameter pa_topo_e TOPO = TOPO_KS
) (
  input  logic [N-1:0] a_i,
  input  logic [N-1:0] b_i,
  input  logic         cin_i,
  output logic [N-1:0] sum_o,
  output logic         cout_o
);
  logic [N-1:0] g_w;
  logic [N-1:0] p_w;
  logic [N-1:0] p_net_w;
  logic [N-1:0] grp_g_w;

  pa_pg_stage #(.N(N)) u_pg (
    .a_i   (a_i),
    .b_i   (b_i),
    .cin_i (cin_i),
    .g_o   (g_w),
    .p_o   (p_w)
  );

  assign p_net_w = {p_w[N-1:1], 1'b0};

  pa_prefix_net #(.N(N), .TOPO(TOPO)) u_net (
    .g_i     (g_w),
    .p_i     (p_net_w),
    .grp_g_o (grp_g_w)
  );

  pa_sum_stage #(.N(N)) u_sum (
    .p_i     (p_w),
    .grp_g_i (grp_g_w),
    .cin_i   (cin_i),
    .sum_o   (sum_o),
    .cout_o  (cout_o)
  );

  logic [N:0] ref_w;
  assign ref_w = {1'b0, a_i} + {1'b0, b_i} + {{N{1'b0}}, cin_i};

  always_comb begin
    a_r1_sum_ref: assert ({cout_o, sum_o} == ref_w)
      else $error("R1: result %h expected %h", {cout_o, sum_o}, ref_w);
    if ((a_i == '0) && (b_i == '0)) begin
      a_r3_cin_only: assert (!cout_o && (sum_o == {{(N-1){1'b0}}, cin_i}))
        else $error("R3: zero operands gave %h", {cout_o, sum_o});
    end
    if ((a_i ^ b_i) == '1) begin
      a_r4_full_propagate: assert ((cout_o == cin_i) && (sum_o == {N{~cin_i}}))
        else $error("R4: full propagate gave %h", {cout_o, sum_o});
    end
  end
endmodule

// File: tb/sim_pa_prefix_adder.sv
module sim_pa_prefix_adder;
  import pa_pkg::*;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #5 clk = ~clk;

  logic [31:0] a_q = '0;
  logic [31:0] b_q = '0;
  logic        c_q = 1'b0;

  logic [15:0] s16 [4];
  logic        co16 [4];
  logic [31:0] s32 [4];
  logic        co32 [4];

  int n_chk = 0;
  int n_fail = 0;

  for (genvar t = 0; t < 4; t++) begin : g16
    pa_prefix_adder #(.N(16), .TOPO(pa_topo_e'(t))) u0 (
      .a_i(a_q[15:0]), .b_i(b_q[15:0]), .cin_i(c_q),
      .sum_o(s16[t]), .cout_o(co16[t]));
  end
  for (genvar t = 0; t < 4; t++) begin : g32
    pa_prefix_adder #(.N(32), .TOPO(pa_topo_e'(t))) u0 (
      .a_i(a_q), .b_i(b_q), .cin_i(c_q),
      .sum_o(s32[t]), .cout_o(co32[t]));
  end

  localparam int NV = 12;
  localparam logic [64:0] VEC [NV] = '{
    {32'h0000_0000, 32'h0000_0000, 1'b0},  // R3
    {32'h0000_0000, 32'h0000_0000, 1'b1},  // R3
    {32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1},  // R6
    {32'hFFFF_FFFF, 32'h0000_0000, 1'b1},  // R4
    {32'hAAAA_AAAA, 32'h5555_5555, 1'b0},  // R4
    {32'hAAAA_AAAA, 32'h5555_5555, 1'b1},  // R4
    {32'h8000_8000, 32'h8000_8000, 1'b0},  // R1
    {32'h0000_FFFF, 32'h0000_0001, 1'b0},  // R1
    {32'h1234_5678, 32'h9ABC_DEF0, 1'b1},  // R1
    {32'h7FFF_7FFF, 32'h0001_0001, 1'b0},  // R5
    {32'hF0F0_F0F0, 32'h0F0F_0F0F, 1'b1},  // R4
    {32'h00FF_00FF, 32'h0001_0001, 1'b0}   // R7
  };
  localparam string TAG [NV] = '{"R3", "R3", "R6", "R4", "R4", "R4",
                                 "R1", "R1", "R1", "R5", "R4", "R7"};

  task automatic chk(input string tag, input logic [32:0] got, input logic [32:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic apply(input logic [31:0] a, input logic [31:0] b, input logic c,
                       input string tag);
    logic [16:0] e16;
    logic [32:0] e32;
    @(posedge clk);
    #1;
    a_q = a; b_q = b; c_q = c;
    #3;
    e16 = {1'b0, a[15:0]} + {1'b0, b[15:0]} + {16'b0, c};
    e32 = {1'b0, a} + {1'b0, b} + {32'b0, c};
    for (int t = 0; t < 4; t++) begin
      chk(tag, {16'b0, co16[t], s16[t]}, {16'b0, e16});
      chk(tag, {co32[t], s32[t]}, e32);
    end
    // R2: all topologies agree at each width
    for (int t = 1; t < 4; t++) begin
      chk("R2", {16'b0, co16[t], s16[t]}, {16'b0, co16[0], s16[0]});
      chk("R2", {co32[t], s32[t]}, {co32[0], s32[0]});
    end
  endtask

  initial begin : watchdog
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    logic [31:0] lfsr;
    repeat (3) @(posedge clk);
    #4;
    // reset state: zero inputs give zero outputs (R3)
    for (int t = 0; t < 4; t++) begin
      chk("R3", {16'b0, co16[t], s16[t]}, 33'd0);
      chk("R3", {co32[t], s32[t]}, 33'd0);
    end
    rst_ni = 1'b1;

    for (int v = 0; v < NV; v++)
      apply(VEC[v][64:33], VEC[v][32:1], VEC[v][0], TAG[v]);

    // R7: zero-zero bits stop carries from below
    apply(32'h00FF_FFFF, 32'h0000_0001, 1'b1, "R7");
    apply(32'h7FFF_7FFF, 32'h0000_0000, 1'b1, "R7");
    // R6 at 16 bits only in low half
    apply(32'h0000_FFFF, 32'h0000_FFFF, 1'b1, "R6");
    // R5: long carry chain stopping mid-word
    apply(32'h0FFF_FFFF, 32'h0000_0001, 1'b0, "R5");

    lfsr = 32'hACE1_2468;
    for (int k = 0; k < 400; k++) begin
      logic [31:0] ra;
      logic [31:0] rb;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      ra = lfsr;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      rb = lfsr ^ {lfsr[15:0], lfsr[31:16]};
      apply(ra, rb, lfsr[7], "R1");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule